// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block sits between a cache and a 64-bit memory data bus and runs one cache-line refill at a time. The cache hands it a line address and the index of the 32-bit word that the processor stalled on. The block sends one burst request whose address points at the doubleword holding that word. The memory then returns the four doublewords of the line, starting with that doubleword and wrapping round the line.

Every accepted beat is passed to the cache with the line offset it belongs to, so the cache never has to assume ascending order. In the cycle the first beat is taken, the block also pulls out the stalled word and raises a one-cycle early-restart strobe with it, well before the rest of the line is in. One cycle after the fourth beat a completion pulse marks the line as whole. While a fill is in progress, further refill requests are held off. Both memory channels use valid/ready handshakes, so the memory may stall the address or any beat for as long as it likes.

Top module: `line_fill_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, fill_ready_o is 1 and mem_req_valid_o, mem_beat_ready_o, beat_valid_o, critical_valid_o and line_done_o are 0.
- R2: A fill is taken when fill_valid_i and fill_ready_o are both high at a clock edge. From the next cycle, mem_req_valid_o is high with mem_req_addr_o = {line address, word index bits [2:1], 3'b000}, and both stay unchanged until a cycle in which mem_req_ready_i is high.
- R3: fill_ready_o is low from the cycle after a fill is taken up to and including the line_done_o cycle. A fill_valid_i seen during that time is ignored: it starts no burst and does not change the address of the burst in progress.
- R4: mem_beat_ready_o is high only after the address handshake and until the fourth beat is taken. A beat counts only when mem_beat_valid_i and mem_beat_ready_o are both high, and beat_valid_o is high in exactly those cycles.
- R5: The k-th accepted beat (k = 0..3) carries beat_offset_o = (word index[2:1] + k) mod 4 and beat_data_o = mem_beat_data_i, in the same cycle.
- R6: critical_valid_o is high only in the cycle the first beat of a fill is taken. In that cycle critical_word_o holds the requested word, which is bits [63:32] of the beat when word index[0] is 1 and bits [31:0] when it is 0.
- R7: line_done_o is high for exactly one cycle, the cycle after the fourth beat is taken. fill_ready_o returns high in the cycle after that.
- R8: In a data-phase cycle with mem_beat_valid_i low, no beat is reported and the offset given to the next beat does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Refill request |
| fill_ready_o | output | 1 | Sequencer idle, request can be taken |
| fill_line_i | input | 27 | Line address (byte address bits [31:5]) |
| fill_widx_i | input | 3 | Index of the requested 32-bit word in the line |
| mem_req_valid_o | output | 1 | Burst request valid |
| mem_req_ready_i | input | 1 | Memory takes the burst request |
| mem_req_addr_o | output | 32 | Byte address of the critical doubleword |
| mem_beat_valid_i | input | 1 | Memory beat valid |
| mem_beat_ready_o | output | 1 | Sequencer takes a beat |
| mem_beat_data_i | input | 64 | Beat data, even word in the low half |
| beat_valid_o | output | 1 | Beat delivered to the cache |
| beat_offset_o | output | 2 | Doubleword offset of the beat in the line |
| beat_data_o | output | 64 | Beat data to the cache |
| critical_valid_o | output | 1 | Early-restart strobe |
| critical_word_o | output | 32 | Requested word |
| line_done_o | output | 1 | Line fill complete |

## Verification
The first accepted beat has two jobs at once: it is delivered with its offset as an ordinary beat, and it is also the source of the early-restart word. The bench cycles the requested index over all eight values and then picks it at random. In that cycle it checks the strobe, the selected half, the offset tag and the data against a queue-based model. A second collision is a new request that arrives in the line_done_o cycle or during the burst. The bench keeps fill_valid_i high at random, so such requests are common. It then requires fill_ready_o to stay low and the next burst address to reflect only a request taken after completion.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_DONE
  } fill_phase_e;
endpackage

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
  import lfs_pkg::*;
#(
  parameter int LINE_ADDR_W = 27,
  parameter int WIDX_W      = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_valid_i,
  input  logic [LINE_ADDR_W-1:0] fill_line_i,
  input  logic [WIDX_W-1:0]      fill_widx_i,
  input  logic                   mem_req_ready_i,
  input  logic                   beat_fire_i,
  input  logic                   last_beat_i,
  output logic                   fill_ready_o,
  output logic                   accept_o,
  output logic                   mem_req_valid_o,
  output logic                   mem_beat_ready_o,
  output logic                   line_done_o,
  output logic [LINE_ADDR_W-1:0] line_o,
  output logic [WIDX_W-1:0]      widx_o
);
  fill_phase_e phase_q, phase_d;
  logic [LINE_ADDR_W-1:0] line_q;
  logic [WIDX_W-1:0]      widx_q;

  assign fill_ready_o     = (phase_q == PH_IDLE);
  assign accept_o         = fill_ready_o & fill_valid_i;
  assign mem_req_valid_o  = (phase_q == PH_ADDR);
  assign mem_beat_ready_o = (phase_q == PH_DATA);
  assign line_done_o      = (phase_q == PH_DONE);
  assign line_o           = line_q;
  assign widx_o           = widx_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (fill_valid_i) phase_d = PH_ADDR;
      PH_ADDR: if (mem_req_ready_i) phase_d = PH_DATA;
      PH_DATA: if (beat_fire_i && last_beat_i) phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      line_q  <= '0;
      widx_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept_o) begin
        line_q <= fill_line_i;
        widx_q <= fill_widx_i;
      end
    end
  end

  // R2
  accept_to_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> mem_req_valid_o);

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(line_o) && $stable(widx_o));

  // R4
  beat_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_beat_ready_o |-> !mem_req_valid_o && !fill_ready_o);

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o && fill_ready_o);
endmodule

// File: rtl/lfs_beat_seq.sv
module lfs_beat_seq #(
  parameter int BEATS      = 4,
  parameter int BEAT_IDX_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  fire_i,
  input  logic [BEAT_IDX_W-1:0] start_i,
  output logic [BEAT_IDX_W-1:0] offset_o,
  output logic                  first_o,
  output logic                  last_o
);
  logic [BEAT_IDX_W-1:0] cnt_q;

  // offset wraps modulo the beat count (power of two)
  assign offset_o = start_i + cnt_q;
  assign first_o  = (cnt_q == '0);
  assign last_o   = (cnt_q == BEAT_IDX_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (fire_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i && !clear_i && $stable(start_i) |=> $stable(offset_o));

  // R7
  last_then_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && last_o |=> first_o);
endmodule

// File: rtl/lfs_crit_pick.sv
module lfs_crit_pick #(
  parameter int BUS_W  = 64,
  parameter int WORD_W = 32,
  parameter int SUB_W  = 1
) (
  input  logic [BUS_W-1:0]  beat_i,
  input  logic [SUB_W-1:0]  sel_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int LANES = BUS_W / WORD_W;

  logic [WORD_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = beat_i[g*WORD_W +: WORD_W];
  end

  assign word_o = lane[sel_i];
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int LINE_ADDR_W = 27,
  parameter int LINE_WORDS  = 8,
  parameter int WORD_W      = 32,
  parameter int BUS_W       = 64,
  localparam int WIDX_W      = $clog2(LINE_WORDS),
  localparam int LANES       = BUS_W / WORD_W,
  localparam int SUB_W       = $clog2(LANES),
  localparam int BEATS       = LINE_WORDS / LANES,
  localparam int BEAT_IDX_W  = $clog2(BEATS),
  localparam int BYTE_OFF_W  = $clog2(BUS_W / 8),
  localparam int ADDR_W      = LINE_ADDR_W + BEAT_IDX_W + BYTE_OFF_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_valid_i,
  output logic                   fill_ready_o,
  input  logic [LINE_ADDR_W-1:0] fill_line_i,
  input  logic [WIDX_W-1:0]      fill_widx_i,
  output logic                   mem_req_valid_o,
  input  logic                   mem_req_ready_i,
  output logic [ADDR_W-1:0]      mem_req_addr_o,
  input  logic                   mem_beat_valid_i,
  output logic                   mem_beat_ready_o,
  input  logic [BUS_W-1:0]       mem_beat_data_i,
  output logic                   beat_valid_o,
  output logic [BEAT_IDX_W-1:0]  beat_offset_o,
  output logic [BUS_W-1:0]       beat_data_o,
  output logic                   critical_valid_o,
  output logic [WORD_W-1:0]      critical_word_o,
  output logic                   line_done_o
);
  logic                   accept;
  logic                   beat_fire;
  logic                   first_beat, last_beat;
  logic [LINE_ADDR_W-1:0] line_q;
  logic [WIDX_W-1:0]      widx_q;
  logic [BEAT_IDX_W-1:0]  crit_beat;
  logic [SUB_W-1:0]       crit_lane;

  assign crit_beat = widx_q[WIDX_W-1:SUB_W];
  assign crit_lane = widx_q[SUB_W-1:0];
  assign beat_fire = mem_beat_valid_i & mem_beat_ready_o;

  lfs_ctrl #(
    .LINE_ADDR_W(LINE_ADDR_W),
    .WIDX_W     (WIDX_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .fill_valid_i    (fill_valid_i),
    .fill_line_i     (fill_line_i),
    .fill_widx_i     (fill_widx_i),
    .mem_req_ready_i (mem_req_ready_i),
    .beat_fire_i     (beat_fire),
    .last_beat_i     (last_beat),
    .fill_ready_o    (fill_ready_o),
    .accept_o        (accept),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_beat_ready_o(mem_beat_ready_o),
    .line_done_o     (line_done_o),
    .line_o          (line_q),
    .widx_o          (widx_q)
  );

  lfs_beat_seq #(
    .BEATS     (BEATS),
    .BEAT_IDX_W(BEAT_IDX_W)
  ) u_beat_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .fire_i  (beat_fire),
    .start_i (crit_beat),
    .offset_o(beat_offset_o),
    .first_o (first_beat),
    .last_o  (last_beat)
  );

  lfs_crit_pick #(
    .BUS_W (BUS_W),
    .WORD_W(WORD_W),
    .SUB_W (SUB_W)
  ) u_crit_pick (
    .beat_i(mem_beat_data_i),
    .sel_i (crit_lane),
    .word_o(critical_word_o)
  );

  assign mem_req_addr_o   = {line_q, crit_beat, {BYTE_OFF_W{1'b0}}};
  assign beat_valid_o     = beat_fire;
  assign beat_data_o      = mem_beat_data_i;
  assign critical_valid_o = beat_fire & first_beat;

  // R6
  crit_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    critical_valid_o |-> beat_valid_o && (beat_offset_o == crit_beat));

  // R7
  done_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> $past(beat_valid_o));

  // R3
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_ready_o && fill_valid_i |=> !mem_req_valid_o || $stable(mem_req_addr_o));
endmodule

// File: tb/line_fill_seq_tb.sv
module line_fill_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fill_valid_i = 1'b0;
  logic        fill_ready_o;
  logic [26:0] fill_line_i = '0;
  logic [2:0]  fill_widx_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_beat_valid_i = 1'b0;
  logic        mem_beat_ready_o;
  logic [63:0] mem_beat_data_i = '0;
  logic        beat_valid_o;
  logic [1:0]  beat_offset_o;
  logic [63:0] beat_data_o;
  logic        critical_valid_o;
  logic [31:0] critical_word_o;
  logic        line_done_o;

  always #2 clk = ~clk;

  line_fill_seq u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .fill_valid_i    (fill_valid_i),
    .fill_ready_o    (fill_ready_o),
    .fill_line_i     (fill_line_i),
    .fill_widx_i     (fill_widx_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_beat_valid_i(mem_beat_valid_i),
    .mem_beat_ready_o(mem_beat_ready_o),
    .mem_beat_data_i (mem_beat_data_i),
    .beat_valid_o    (beat_valid_o),
    .beat_offset_o   (beat_offset_o),
    .beat_data_o     (beat_data_o),
    .critical_valid_o(critical_valid_o),
    .critical_word_o (critical_word_o),
    .line_done_o     (line_done_o)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // memory content: low word even, high word odd
  function automatic logic [63:0] pat(input logic [26:0] line, input logic [1:0] dw);
    return {line, dw, 3'd5, line ^ 27'h5a5a5a5, dw, 3'd2};
  endfunction

  // reference model state
  int          phase = 0;       // 0 idle, 1 addr, 2 data, 3 done
  int          exp_off[$];
  logic [26:0] m_line = '0;
  logic [2:0]  m_idx = '0;
  int          n_fills = 0;
  int          n_done = 0;
  int          dut_done_seen = 0;
  int          cyc = 0;
  logic [63:0] mem_q[$];

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(fill_ready_o === 1'b1, "R1", "fill_ready in reset", 64'(fill_ready_o), 1);
    chk(mem_req_valid_o === 1'b0, "R1", "mem_req_valid in reset", 64'(mem_req_valid_o), 0);
    chk(mem_beat_ready_o === 1'b0, "R1", "mem_beat_ready in reset", 64'(mem_beat_ready_o), 0);
    chk(line_done_o === 1'b0 && critical_valid_o === 1'b0 && beat_valid_o === 1'b0,
        "R1", "strobes in reset", {line_done_o, critical_valid_o, beat_valid_o}, 0);
    rst_ni = 1'b1;

    while (n_done < 200 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      // drive
      fill_valid_i = ($urandom % 3) == 0;
      fill_line_i  = 27'($urandom);
      fill_widx_i  = (n_fills < 16) ? 3'(n_fills) : 3'($urandom);
      mem_req_ready_i = ($urandom % 2) == 0;
      if (mem_q.size() > 0) begin
        mem_beat_valid_i = ($urandom % 3) != 0;
        mem_beat_data_i  = mem_q[0];
      end else begin
        mem_beat_valid_i = ($urandom % 4) == 0;
        mem_beat_data_i  = {$urandom, $urandom};
      end
      #1;
      begin
        bit          e_fr, e_rv, e_br, e_bv, e_cv, e_done;
        logic [31:0] e_addr;
        logic [1:0]  e_off;
        logic [31:0] e_word;
        e_fr   = (phase == 0);
        e_rv   = (phase == 1);
        e_br   = (phase == 2);
        e_bv   = (phase == 2) && mem_beat_valid_i;
        e_done = (phase == 3);
        e_off  = (exp_off.size() > 0) ? 2'(exp_off[0]) : 2'd0;
        e_cv   = e_bv && (exp_off.size() == 4);
        e_addr = {m_line, m_idx[2:1], 3'b000};
        e_word = m_idx[0] ? pat(m_line, m_idx[2:1])[63:32] : pat(m_line, m_idx[2:1])[31:0];

        if (cyc == 1) begin
          // R1 first cycle after release
          chk(fill_ready_o === 1'b1 && mem_req_valid_o === 1'b0, "R1", "after release",
              {fill_ready_o, mem_req_valid_o}, 2'b10);
        end
        chk(fill_ready_o === e_fr, "R3", "fill_ready", 64'(fill_ready_o), 64'(e_fr));
        chk(mem_req_valid_o === e_rv, "R2", "mem_req_valid", 64'(mem_req_valid_o), 64'(e_rv));
        if (e_rv)
          chk(mem_req_addr_o === e_addr, "R2", "mem_req_addr", 64'(mem_req_addr_o), 64'(e_addr));
        chk(mem_beat_ready_o === e_br, "R4", "mem_beat_ready", 64'(mem_beat_ready_o), 64'(e_br));
        chk(beat_valid_o === e_bv, "R4", "beat_valid", 64'(beat_valid_o), 64'(e_bv));
        if (e_br && !mem_beat_valid_i)
          chk(beat_valid_o === 1'b0, "R8", "stall beat_valid", 64'(beat_valid_o), 0);
        if (e_bv) begin
          chk(beat_offset_o === e_off, "R5", "beat_offset", 64'(beat_offset_o), 64'(e_off));
          chk(beat_data_o === pat(m_line, e_off), "R5", "beat_data", beat_data_o,
              pat(m_line, e_off));
        end
        chk(critical_valid_o === e_cv, "R6", "critical_valid", 64'(critical_valid_o), 64'(e_cv));
        if (e_cv)
          chk(critical_word_o === e_word, "R6", "critical_word", 64'(critical_word_o),
              64'(e_word));
        chk(line_done_o === e_done, "R7", "line_done", 64'(line_done_o), 64'(e_done));
        if (line_done_o === 1'b1) dut_done_seen++;

        // memory stub, driven by the design's own outputs
        if (mem_req_valid_o === 1'b1 && mem_req_ready_i) begin
          for (int k = 0; k < 4; k++)
            mem_q.push_back(pat(mem_req_addr_o[31:5], 2'(mem_req_addr_o[4:3] + 2'(k))));
        end
        if (mem_beat_valid_i && mem_beat_ready_o === 1'b1 && mem_q.size() > 0)
          void'(mem_q.pop_front());

        // advance model to the next edge
        case (phase)
          0: if (fill_valid_i) begin
               m_line = fill_line_i;
               m_idx  = fill_widx_i;
               for (int k = 0; k < 4; k++) exp_off.push_back((int'(fill_widx_i[2:1]) + k) % 4);
               n_fills++;
               phase = 1;
             end
          1: if (mem_req_ready_i) phase = 2;
          2: if (mem_beat_valid_i) begin
               void'(exp_off.pop_front());
               if (exp_off.size() == 0) begin
                 phase = 3;
                 n_done++;
               end
             end
          default: phase = 0;
        endcase
      end
    end

    if (n_done < 200)
      chk(1'b0, "R7", "watchdog: fills completed", 64'(n_done), 200);
    @(negedge clk);
    #1;
    if (line_done_o === 1'b1) dut_done_seen++;
    // R7 every completed fill produced one done pulse
    chk(dut_done_seen == n_done, "R7", "done pulse count", 64'(dut_done_seen), 64'(n_done));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule